// File: doc/BRIEF.md
# Stereo ADC Serial Output Port

This block takes a pair of 20-bit two's complement samples from a stereo converter core and sends them out on a three-line serial port. The port has a bit clock, a word clock that marks the left and right channels, and a frame-sync line, plus one data line. Everything runs on a single master clock. In master mode the block divides the master clock to make the three port clocks. The divide ratio is 256 or 384 master clocks per sample, set by a pin. In slave mode the three clocks come from outside. The block brings them into the master clock domain and still drives the data line.

Two word formats are supported. In the left-justified format the MSB follows the word clock edge at once, and the left channel goes out while the word clock is high. In the I2S format the MSB comes one bit clock late, and the left channel goes out while the word clock is low. Each 20-bit word is padded with low bits to fill its 32-bit slot. An active-low power-down input resets the block and parks the outputs at fixed levels.

Top module: `adc_serial_port`

## Requirements
- R1: In master mode the bit clock period is 4 master clocks when `ratio384` is 0 and 6 when it is 1. The clock is high for exactly half of each period, and the data bit changes where the clock falls.
- R2: In master mode the word clock has a period of 64 bit clocks. In left-justified format (`fmtI2s`=0) it is high for the 32 bit periods of the left slot and low for the right slot. In I2S format the levels are swapped. It changes only where the bit clock falls.
- R3: In master mode the frame-sync output is high in bit periods 0–15 and 32–47 of each 64-bit frame and low in all the others. This gives twice the sample rate.
- R4: In master mode the data line changes only in the master clock cycle where the bit clock falls.
- R5: In left-justified format, slot positions 0–19 carry the channel sample, MSB first, and positions 20–31 are low. The left slot comes first in the frame.
- R6: In I2S format, slot position 0 is low, positions 1–20 carry the sample MSB first, and positions 21–31 are low.
- R7: Both channel inputs are captured when the left word starts. A change on `leftSample` or `rightSample` later in that frame first shows in the next frame.
- R8: In slave left-justified mode, data advances only on external bit-clock falling edges where frame-sync is high. On a falling edge where frame-sync is low, the line goes low and the bit position holds. A word clock change restarts the word at its MSB, and after 20 sent bits the line stays low.
- R9: In slave I2S mode frame-sync has no effect. After each word clock change the line is low for one bit, then carries the 20 sample bits, then stays low.
- R10: While `pdN` is low, `sclkOut`, `fsyncOut` and `sdata` are low. `lrckOut` is high in master left-justified mode and low otherwise.
- R11: In slave mode `sclkOut`, `lrckOut` and `fsyncOut` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| pdN | input | 1 | Active-low power-down and asynchronous reset |
| masterMode | input | 1 | 1: the block generates the port clocks; 0: the port clocks are taken from outside |
| fmtI2s | input | 1 | 1: I2S format; 0: left-justified format |
| ratio384 | input | 1 | 1: 384 master clocks per sample; 0: 256 |
| leftSample | input | 20 | Left channel sample, two's complement |
| rightSample | input | 20 | Right channel sample, two's complement |
| sclkIn | input | 1 | External bit clock (slave mode) |
| lrckIn | input | 1 | External word clock (slave mode) |
| fsyncIn | input | 1 | External frame-sync (slave mode) |
| sclkOut | output | 1 | Generated bit clock |
| lrckOut | output | 1 | Generated word clock |
| fsyncOut | output | 1 | Generated frame-sync |
| sdata | output | 1 | Serial data |

## Verification
The assertions assume that `masterMode`, `fmtI2s` and `ratio384` change only while `pdN` is low, so the divider phase and the clock-level properties never see a mode change in the middle of a frame. Slave-mode behaviour relies on several more assumptions. The external bit clock must have high and low phases much longer than the two-stage synchronizer. The word clock and frame-sync must change together with the falling bit clock. Sample inputs must not change close to the start of the left word. The stimulus meets all of these. It changes modes only inside power-down, drives the slave bit clock with 8-cycle phases, and moves the word clock and frame-sync together with the falling bit clock. It also changes samples only in the middle of the right slot.

// File: rtl/asp_pkg.sv
package asp_pkg;

  // Strobes passed from control to datapath, one set per bit period.
  typedef struct packed {
    logic bitStb;    // a new bit period starts on this cycle
    logic load;      // capture both channel inputs (left word starts)
    logic send;      // put the next sample bit on the line
    logic selRight;  // the bit period belongs to the right channel
  } dpCtl_t;

endpackage

// File: rtl/asp_sync2.sv
module asp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/asp_ctrl.sv
module asp_ctrl
  import asp_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_BITS = 32,
  parameter int DIV_LO    = 4,
  parameter int DIV_HI    = 6
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   masterMode,
  input  logic   fmtI2s,
  input  logic   ratioHi,
  input  logic   sclkIn,
  input  logic   lrckIn,
  input  logic   fsyncIn,
  output logic   sclkOut,
  output logic   lrckOut,
  output logic   fsyncOut,
  output dpCtl_t ctl
);

  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int BIT_CW     = $clog2(FRAME_BITS);
  localparam int SLOT_CW    = $clog2(SLOT_BITS);
  localparam int DIV_MAX    = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int DIV_CW     = $clog2(DIV_MAX);
  localparam int SENT_CW    = $clog2(SAMPLE_W + 1);

  // ---------------- master clock division ----------------
  logic [DIV_CW-1:0] divCnt, divLast, divHalf;
  logic [BIT_CW-1:0] bitCnt, nextBit;
  logic              mWrap;

  assign divLast = ratioHi ? DIV_CW'(DIV_HI - 1) : DIV_CW'(DIV_LO - 1);
  assign divHalf = ratioHi ? DIV_CW'(DIV_HI / 2) : DIV_CW'(DIV_LO / 2);
  assign mWrap   = masterMode && (divCnt == divLast);
  assign nextBit = bitCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (masterMode) begin
      if (mWrap) begin
        divCnt <= '0;
        bitCnt <= nextBit;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  logic sclkGen, lrckGen, fsyncGen;
  assign sclkGen  = (divCnt >= divHalf);
  assign lrckGen  = fmtI2s ? bitCnt[BIT_CW-1] : ~bitCnt[BIT_CW-1];
  assign fsyncGen = ~bitCnt[SLOT_CW-1];

  assign sclkOut  = rstN & masterMode & sclkGen;
  assign fsyncOut = rstN & masterMode & fsyncGen;
  assign lrckOut  = masterMode & (rstN ? lrckGen : ~fmtI2s);

  // ---------------- slave clock capture ----------------
  logic sclkS, lrckS, fsyncS, sclkPrev, lrckLast, sFall;

  asp_sync2 #(.W(3)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({sclkIn, lrckIn, fsyncIn}),
    .q   ({sclkS, lrckS, fsyncS})
  );

  assign sFall = !masterMode && sclkPrev && !sclkS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      lrckLast <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (sFall) lrckLast <= lrckS;
    end
  end

  // ---------------- shared bit sequencing ----------------
  logic               wordStart, selRight, bitEn, skipBit, sendBit;
  logic [SENT_CW-1:0] sentCnt, sentBase;

  assign wordStart = masterMode ? (nextBit[SLOT_CW-1:0] == '0) : (lrckS != lrckLast);
  assign selRight  = masterMode ? nextBit[BIT_CW-1] : (fmtI2s ? lrckS : ~lrckS);
  assign bitEn     = masterMode || fmtI2s || fsyncS;
  assign sentBase  = wordStart ? '0 : sentCnt;
  assign skipBit   = fmtI2s && wordStart;
  assign sendBit   = !skipBit && bitEn && (sentBase < SENT_CW'(SAMPLE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sentCnt <= SENT_CW'(SAMPLE_W);
    end else if (ctl.bitStb) begin
      sentCnt <= sentBase + SENT_CW'(sendBit);
    end
  end

  always_comb begin
    ctl.bitStb   = masterMode ? mWrap : sFall;
    ctl.load     = ctl.bitStb && wordStart && !selRight;
    ctl.send     = ctl.bitStb && sendBit;
    ctl.selRight = selRight;
  end

endmodule

// File: rtl/asp_datapath.sv
module asp_datapath
  import asp_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  output logic                sdata
);

  logic [SAMPLE_W-1:0] lSh, rSh, lCur, rCur;

  assign lCur = ctl.load ? leftIn  : lSh;
  assign rCur = ctl.load ? rightIn : rSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lSh   <= '0;
      rSh   <= '0;
      sdata <= 1'b0;
    end else if (ctl.bitStb) begin
      sdata <= ctl.send & (ctl.selRight ? rCur[SAMPLE_W-1] : lCur[SAMPLE_W-1]);
      lSh   <= (ctl.send && !ctl.selRight) ? {lCur[SAMPLE_W-2:0], 1'b0} : lCur;
      rSh   <= (ctl.send &&  ctl.selRight) ? {rCur[SAMPLE_W-2:0], 1'b0} : rCur;
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import asp_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_BITS = 32,
  parameter int DIV_LO    = 4,
  parameter int DIV_HI    = 6
) (
  input  logic                mclk,
  input  logic                pdN,
  input  logic                masterMode,
  input  logic                fmtI2s,
  input  logic                ratio384,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                sclkIn,
  input  logic                lrckIn,
  input  logic                fsyncIn,
  output logic                sclkOut,
  output logic                lrckOut,
  output logic                fsyncOut,
  output logic                sdata
);

  dpCtl_t ctl;

  asp_ctrl #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_BITS(SLOT_BITS),
    .DIV_LO   (DIV_LO),
    .DIV_HI   (DIV_HI)
  ) u_ctrl (
    .clk       (mclk),
    .rstN      (pdN),
    .masterMode(masterMode),
    .fmtI2s    (fmtI2s),
    .ratioHi   (ratio384),
    .sclkIn    (sclkIn),
    .lrckIn    (lrckIn),
    .fsyncIn   (fsyncIn),
    .sclkOut   (sclkOut),
    .lrckOut   (lrckOut),
    .fsyncOut  (fsyncOut),
    .ctl       (ctl)
  );

  asp_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) u_dp (
    .clk    (mclk),
    .rstN   (pdN),
    .ctl    (ctl),
    .leftIn (leftSample),
    .rightIn(rightSample),
    .sdata  (sdata)
  );

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input logic mclk,
  input logic pdN,
  input logic masterMode,
  input logic fmtI2s,
  input logic ratio384,
  input logic sclkOut,
  input logic lrckOut,
  input logic fsyncOut,
  input logic sdata
);

  localparam int HCW = $clog2(((DIV_HI > DIV_LO) ? DIV_HI : DIV_LO) + 1);

  // Master clock cycles the bit clock has been seen high.
  logic [HCW-1:0] hiCnt;
  always_ff @(posedge mclk or negedge pdN) begin
    if (!pdN) hiCnt <= '0;
    else      hiCnt <= sclkOut ? hiCnt + 1'b1 : '0;
  end

  AST_SCLK_HALF_HIGH: assert property (@(posedge mclk) disable iff (!pdN || !masterMode)
    $fell(sclkOut) |-> hiCnt == HCW'(ratio384 ? DIV_HI / 2 : DIV_LO / 2)); // R1

  AST_LRCK_ON_FALL: assert property (@(posedge mclk) disable iff (!pdN || !masterMode)
    !$stable(lrckOut) |-> $fell(sclkOut)); // R2

  AST_SDATA_ON_FALL: assert property (@(posedge mclk) disable iff (!pdN || !masterMode)
    !$stable(sdata) |-> $fell(sclkOut)); // R4

  AST_PD_LEVELS: assert property (@(posedge mclk)
    !pdN |-> (!sclkOut && !fsyncOut && !sdata && (lrckOut == (masterMode && !fmtI2s)))); // R10

  AST_SLAVE_QUIET: assert property (@(posedge mclk) disable iff (!pdN)
    !masterMode |-> (!sclkOut && !lrckOut && !fsyncOut)); // R11

endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .mclk      (mclk),
  .pdN       (pdN),
  .masterMode(masterMode),
  .fmtI2s    (fmtI2s),
  .ratio384  (ratio384),
  .sclkOut   (sclkOut),
  .lrckOut   (lrckOut),
  .fsyncOut  (fsyncOut),
  .sdata     (sdata)
);

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;

  logic        mclk = 1'b0;
  logic        pdN = 1'b1;
  logic        masterMode = 1'b1;
  logic        fmtI2s = 1'b0;
  logic        ratio384 = 1'b0;
  logic [19:0] leftSample = '0;
  logic [19:0] rightSample = '0;
  logic        sclkIn = 1'b1;
  logic        lrckIn = 1'b0;
  logic        fsyncIn = 1'b0;
  logic        sclkOut, lrckOut, fsyncOut, sdata;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  always #10 mclk = ~mclk;
  always @(posedge mclk) cyc <= cyc + 1;

  adc_serial_port i_adc_serial_port (
    .mclk(mclk), .pdN(pdN), .masterMode(masterMode), .fmtI2s(fmtI2s),
    .ratio384(ratio384), .leftSample(leftSample), .rightSample(rightSample),
    .sclkIn(sclkIn), .lrckIn(lrckIn), .fsyncIn(fsyncIn),
    .sclkOut(sclkOut), .lrckOut(lrckOut), .fsyncOut(fsyncOut), .sdata(sdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] lval(input int f);
    case (f)
      1:       lval = 20'h80000;
      2:       lval = 20'h7FFFF;
      default: lval = 20'(f * 20'h2D5B3 + 20'h1F0E1);
    endcase
  endfunction

  function automatic logic [19:0] rval(input int f);
    logic [19:0] v;
    v = lval(f);
    rval = {v[9:0], v[19:10]} ^ 20'h5A5A5;
  endfunction

  task automatic powerDown(input logic mst, input logic i2s, input logic hi);
    @(negedge mclk);
    pdN = 1'b0;
    #1;
    chk("R10 sclk in power-down", int'(sclkOut), 0);
    chk("R10 fsync in power-down", int'(fsyncOut), 0);
    chk("R10 sdata in power-down", int'(sdata), 0);
    masterMode = mst; fmtI2s = i2s; ratio384 = hi;
    #1;
    chk("R10 lrck level in power-down", int'(lrckOut), int'(mst && !i2s));
    repeat (3) @(negedge mclk);
  endtask

  task automatic runMaster(input logic hi, input logic i2s);
    int div = hi ? 6 : 4;
    int lastCyc = 0;
    powerDown(1'b1, i2s, hi);
    leftSample = lval(0); rightSample = rval(0);
    pdN = 1'b1;
    for (int k = 0; k < 256; k++) begin
      int bc, fr, s, ch, idx, expBit;
      logic [19:0] w;
      @(posedge sclkOut);
      @(negedge mclk);
      bc = k % 64; fr = k / 64; s = bc % 32; ch = bc / 32;
      chk("R2 word clock level", int'(lrckOut), i2s ? ch : 1 - ch);
      chk("R3 frame-sync level", int'(fsyncOut), (bc % 32) < 16 ? 1 : 0);
      if (k > 0) chk("R1 bit clock period", cyc - lastCyc, div);
      lastCyc = cyc;
      if (fr >= 1) begin
        w = (ch == 1) ? rval(fr) : lval(fr);
        idx = i2s ? s - 1 : s;
        expBit = (idx >= 0 && idx < 20) ? int'(w[19 - idx]) : 0;
        if (ch == 1 && bc > 40)
          chk("R7 right word unaffected by input change", int'(sdata), expBit);
        else
          chk(i2s ? "R6 I2S slot bit" : "R5 left-justified slot bit", int'(sdata), expBit);
      end
      if (bc == 40) begin
        leftSample = lval(fr + 1); rightSample = rval(fr + 1);
      end
    end
  endtask

  task automatic slaveBit(input logic lr, input logic fs, output logic sd);
    @(negedge mclk);
    sclkIn = 1'b0; lrckIn = lr; fsyncIn = fs;
    repeat (8) @(negedge mclk);
    sclkIn = 1'b1;
    repeat (7) @(negedge mclk);
    sd = sdata;
    chk("R11 slave sclkOut", int'(sclkOut), 0);
    chk("R11 slave lrckOut", int'(lrckOut), 0);
    chk("R11 slave fsyncOut", int'(fsyncOut), 0);
  endtask

  task automatic runSlave(input logic i2s);
    logic leftLvl, sd;
    int sent;
    powerDown(1'b0, i2s, 1'b0);
    leftLvl = i2s ? 1'b0 : 1'b1;
    sclkIn = 1'b1; lrckIn = ~leftLvl; fsyncIn = 1'b1;
    leftSample = lval(1); rightSample = rval(1);
    @(negedge mclk);
    pdN = 1'b1;
    repeat (4) @(negedge mclk);
    for (int j = 0; j < 4; j++) slaveBit(~leftLvl, 1'b1, sd);
    sent = 0;
    for (int f = 1; f <= 3; f++) begin
      for (int b = 0; b < 64; b++) begin
        logic lr, fs;
        logic [19:0] w;
        int expBit;
        lr = (b < 32) ? leftLvl : ~leftLvl;
        if (i2s) fs = 1'(b % 2);
        else fs = !((b >= 5 && b <= 7) || (b >= 32 && b <= 34) || (f == 2 && b % 3 == 0));
        slaveBit(lr, fs, sd);
        w = (b < 32) ? lval(f) : rval(f);
        if (b == 0 || b == 32) sent = 0;
        if (i2s && (b == 0 || b == 32)) expBit = 0;
        else if ((i2s || fs) && sent < 20) begin
          expBit = int'(w[19 - sent]);
          sent++;
        end else expBit = 0;
        chk(i2s ? "R9 slave I2S bit" : "R8 slave gated bit", int'(sd), expBit);
        if (b == 40) begin
          leftSample = lval(f + 1); rightSample = rval(f + 1);
        end
      end
    end
  endtask

  initial begin
    #1 pdN = 1'b0;
    @(negedge mclk);
    chk("R10 reset sclk", int'(sclkOut), 0);
    chk("R10 reset sdata", int'(sdata), 0);
    chk("R10 reset lrck", int'(lrckOut), 1);
    for (int c = 0; c < 4; c++) runMaster(1'(c / 2), 1'(c % 2));
    runSlave(1'b0);
    runSlave(1'b1);
    powerDown(1'b1, 1'b0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule